// File: doc/BRIEF.md
# Receive Frame Length Limiter

The block sits between an infrared deframer and a receive FIFO. Each byte the deframer presents passes straight through to the FIFO write port in the same cycle, unless the current frame has already reached a maximum length that software has programmed. A 13-bit up counter tracks the bytes accepted in the current frame. Software can read this count at any time, together with the programmed limit.

The deframer marks the start of each frame with a one-cycle `startFlag` pulse. This pulse clears the counter and re-opens the FIFO path. If a byte arrives while the count already equals or exceeds a non-zero limit, the byte is dropped. The block then raises a sticky over-length status bit and enters a discard state. In the discard state every further byte is thrown away until the next start flag. The status bit stays set across frames until software clears it. A limit of zero turns the check off.

Top module: `rxlen_guard`

## Requirements
- R1: After reset the limit reads 0, the frame count reads 0, the over-length flag is 0, the block accepts bytes, and `fifoWrEn` is low while `byteValid` is low.
- R2: A pulse on `limLoWr` loads `cfgWrData[7:0]` into limit bits 7..0. A pulse on `limHiWr` loads `cfgWrData[4:0]` into limit bits 12..8 and ignores `cfgWrData[7:5]`. `limitOut` shows the limit from the next cycle on.
- R3: A `startFlag` pulse sets `frameCnt` to 0 in the next cycle and returns the block to the accepting state. `startFlag` and `byteValid` are never high in the same cycle.
- R4: In the accepting state, a byte with `byteValid` high is passed on when the limit is 0 or `frameCnt` is below the limit. It is passed in the same cycle, with `fifoWrEn` high and `fifoWrData` equal to `byteData`, and `frameCnt` rises by one in the next cycle.
- R5: In the accepting state, a byte that arrives when the limit is non-zero and `frameCnt` is equal to or above it is dropped, with `fifoWrEn` low. In the next cycle `overLenFlag` is 1 and `discarding` is 1. This also holds when the limit is lowered below the running count during a frame.
- R6: While `discarding` is 1, `fifoWrEn` stays low and `frameCnt` holds its value whatever `byteValid` does, until a `startFlag` pulse.
- R7: `overLenFlag` stays set until an `overLenClr` pulse clears it in the next cycle, and a start flag does not clear it. When a drop and a clear happen in the same cycle, the flag is set.
- R8: With a limit of 0 every byte is passed on, and `frameCnt` stops at 8191 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startFlag | input | 1 | One-cycle pulse at each frame start |
| byteValid | input | 1 | A received byte is present |
| byteData | input | 8 | Received byte |
| fifoWrEn | output | 1 | Write strobe to the receive FIFO |
| fifoWrData | output | 8 | Data to the receive FIFO |
| limLoWr | input | 1 | Load low byte of the limit |
| limHiWr | input | 1 | Load high bits of the limit |
| cfgWrData | input | 8 | Data for limit writes |
| overLenClr | input | 1 | Clears the over-length flag |
| limitOut | output | 13 | Programmed limit |
| frameCnt | output | 13 | Bytes accepted in the current frame |
| overLenFlag | output | 1 | Sticky over-length status |
| discarding | output | 1 | High while the rest of a frame is being dropped |

## Verification
The assertions assume that the deframer never raises `startFlag` and `byteValid` in the same cycle. One assertion flags any breach of this rule rather than giving the case a meaning. The directed stimulus always drives the start pulse and the bytes on separate clock cycles, and it only changes the limit between bytes. Because of this, every check of the count and of the drop point refers to a clean frame boundary.

// File: rtl/rxlen_guard_pkg.sv
package rxlen_guard_pkg;

  typedef enum logic {
    ST_ACCEPT  = 1'b0,
    ST_DISCARD = 1'b1
  } guardState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
  } cntStrobe_t;

endpackage

// File: rtl/rxlen_guard_dp.sv
module rxlen_guard_dp
  import rxlen_guard_pkg::*;
#(
  parameter int CNT_W  = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntStrobe_t        strobe,
  input  logic              limLoWr,
  input  logic              limHiWr,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic              atLimit,
  output logic [CNT_W-1:0]  limitOut,
  output logic [CNT_W-1:0]  frameCnt
);

  localparam int HI_W = CNT_W - DATA_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [DATA_W-1:0] limLo;
  logic [HI_W-1:0]   limHi;
  logic [CNT_W-1:0]  cnt;
  logic              unusedCfgHi;

  assign unusedCfgHi = ^cfgWrData[DATA_W-1:HI_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limLo <= '0;
      limHi <= '0;
    end else begin
      if (limLoWr) limLo <= cfgWrData;
      if (limHiWr) limHi <= cfgWrData[HI_W-1:0];
    end
  end

  assign limitOut = {limHi, limLo};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.clrCnt) begin
      cnt <= '0;
    end else if (strobe.incCnt && (cnt != CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign frameCnt = cnt;
  assign atLimit  = (limitOut != '0) && (cnt >= limitOut);

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrCnt |=> (frameCnt == '0)); // R3

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incCnt && !strobe.clrCnt && frameCnt != CNT_MAX)
      |=> (frameCnt == $past(frameCnt) + 1'b1)); // R4

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.incCnt && !strobe.clrCnt) |=> $stable(frameCnt)); // R6

  AST_LIM_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    limLoWr |=> (limitOut[DATA_W-1:0] == $past(cfgWrData))); // R2

endmodule

// File: rtl/rxlen_guard_ctrl.sv
module rxlen_guard_ctrl
  import rxlen_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startFlag,
  input  logic       byteValid,
  input  logic       atLimit,
  input  logic       overLenClr,
  output cntStrobe_t strobe,
  output logic       fifoWrEn,
  output logic       overLenFlag,
  output logic       discarding
);

  guardState_t st, stNext;
  logic        accepting;
  logic        passByte;
  logic        dropByte;
  logic        flagReg;

  always_comb begin
    accepting = (st == ST_ACCEPT);
    passByte  = accepting && byteValid && !startFlag && !atLimit;
    dropByte  = accepting && byteValid && !startFlag && atLimit;

    strobe.clrCnt = startFlag;
    strobe.incCnt = passByte;

    stNext = st;
    if (startFlag)     stNext = ST_ACCEPT;
    else if (dropByte) stNext = ST_DISCARD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_ACCEPT;
      flagReg <= 1'b0;
    end else begin
      st <= stNext;
      if (dropByte)        flagReg <= 1'b1;
      else if (overLenClr) flagReg <= 1'b0;
    end
  end

  assign fifoWrEn    = passByte;
  assign overLenFlag = flagReg;
  assign discarding  = (st == ST_DISCARD);

  AST_DISCARD_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    discarding |-> !fifoWrEn); // R6

  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (accepting && byteValid && !fifoWrEn) |=> (overLenFlag && discarding)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overLenFlag && !overLenClr) |=> overLenFlag); // R7

  AST_START_REOPENS: assert property (@(posedge clk) disable iff (!rstN)
    startFlag |=> !discarding); // R3

endmodule

// File: rtl/rxlen_guard.sv
module rxlen_guard
  import rxlen_guard_pkg::*;
#(
  parameter int CNT_W  = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startFlag,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  output logic              fifoWrEn,
  output logic [DATA_W-1:0] fifoWrData,
  input  logic              limLoWr,
  input  logic              limHiWr,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              overLenClr,
  output logic [CNT_W-1:0]  limitOut,
  output logic [CNT_W-1:0]  frameCnt,
  output logic              overLenFlag,
  output logic              discarding
);

  cntStrobe_t strobe;
  logic       atLimit;

  rxlen_guard_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startFlag  (startFlag),
    .byteValid  (byteValid),
    .atLimit    (atLimit),
    .overLenClr (overLenClr),
    .strobe     (strobe),
    .fifoWrEn   (fifoWrEn),
    .overLenFlag(overLenFlag),
    .discarding (discarding)
  );

  rxlen_guard_dp #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .limLoWr  (limLoWr),
    .limHiWr  (limHiWr),
    .cfgWrData(cfgWrData),
    .atLimit  (atLimit),
    .limitOut (limitOut),
    .frameCnt (frameCnt)
  );

  assign fifoWrData = byteData;

  AST_IN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(startFlag && byteValid)); // R3

  AST_ZERO_LIMIT_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (limitOut == '0 && byteValid && !discarding) |-> fifoWrEn); // R8

endmodule

// File: tb/test_rxlen_guard.sv
`timescale 1ns/1ps
module test_rxlen_guard;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startFlag = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        fifoWrEn;
  logic [7:0]  fifoWrData;
  logic        limLoWr = 1'b0;
  logic        limHiWr = 1'b0;
  logic [7:0]  cfgWrData = '0;
  logic        overLenClr = 1'b0;
  logic [12:0] limitOut;
  logic [12:0] frameCnt;
  logic        overLenFlag;
  logic        discarding;

  int vecs = 0;
  int errs = 0;

  always #2.5 clk = ~clk;

  rxlen_guard i_rxlen_guard (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wrLimit(logic [7:0] lo, logic [7:0] hi);
    @(negedge clk); limLoWr = 1'b1; cfgWrData = lo;
    @(negedge clk); limLoWr = 1'b0; limHiWr = 1'b1; cfgWrData = hi;
    @(negedge clk); limHiWr = 1'b0; cfgWrData = '0;
  endtask

  task automatic frameStart();
    @(negedge clk); startFlag = 1'b1;
    @(negedge clk); startFlag = 1'b0;
  endtask

  // Drive one byte for one cycle and check the write strobe at once
  task automatic sendByte(logic [7:0] d, logic expWr, string req);
    @(negedge clk); byteValid = 1'b1; byteData = d;
    #1;
    chk(req, "fifoWrEn", fifoWrEn, expWr);
    if (expWr) chk(req, "fifoWrData", fifoWrData, d);
    @(negedge clk); byteValid = 1'b0;
  endtask

  task automatic tReset();
    @(negedge clk);
    chk("R1", "limitOut", limitOut, 0);
    chk("R1", "frameCnt", frameCnt, 0);
    chk("R1", "overLenFlag", overLenFlag, 0);
    chk("R1", "discarding", discarding, 0);
    chk("R1", "fifoWrEn", fifoWrEn, 0);
  endtask

  task automatic tLimitRegs();
    wrLimit(8'h34, 8'hE2);
    chk("R2", "limitOut hi bits masked", limitOut, 13'h0234);
    wrLimit(8'h03, 8'h00);
    chk("R2", "limitOut=3", limitOut, 3);
  endtask

  task automatic tOverflow();
    frameStart();
    chk("R3", "frameCnt after start", frameCnt, 0);
    sendByte(8'hA1, 1'b1, "R4");
    sendByte(8'hB2, 1'b1, "R4");
    sendByte(8'hC3, 1'b1, "R4");
    chk("R4", "frameCnt=3", frameCnt, 3);
    chk("R5", "no flag yet", overLenFlag, 0);
    sendByte(8'hD4, 1'b0, "R5");
    chk("R5", "overLenFlag", overLenFlag, 1);
    chk("R5", "discarding", discarding, 1);
    chk("R5", "frameCnt holds", frameCnt, 3);
    sendByte(8'hE5, 1'b0, "R6");
    sendByte(8'hF6, 1'b0, "R6");
    chk("R6", "frameCnt frozen", frameCnt, 3);
    chk("R6", "still discarding", discarding, 1);
    frameStart();
    chk("R3", "reopened", discarding, 0);
    chk("R3", "frameCnt cleared", frameCnt, 0);
    chk("R7", "flag survives start", overLenFlag, 1);
    sendByte(8'h11, 1'b1, "R3");
    chk("R4", "frameCnt=1", frameCnt, 1);
  endtask

  task automatic tClear();
    @(negedge clk); overLenClr = 1'b1;
    @(negedge clk); overLenClr = 1'b0;
    chk("R7", "flag cleared", overLenFlag, 0);
    sendByte(8'h22, 1'b1, "R4");
    sendByte(8'h33, 1'b1, "R4");
    // Drop and clear in the same cycle: set wins
    @(negedge clk); byteValid = 1'b1; byteData = 8'h44; overLenClr = 1'b1;
    #1;
    chk("R7", "fifoWrEn on drop", fifoWrEn, 0);
    @(negedge clk); byteValid = 1'b0; overLenClr = 1'b0;
    chk("R7", "set wins over clear", overLenFlag, 1);
  endtask

  task automatic tLowerMidFrame();
    wrLimit(8'h00, 8'h00);
    frameStart();
    for (int i = 0; i < 5; i++) sendByte(8'(i + 8'h50), 1'b1, "R8");
    chk("R8", "frameCnt=5 limit off", frameCnt, 5);
    wrLimit(8'h02, 8'h00);
    sendByte(8'h77, 1'b0, "R5");
    chk("R5", "lowered limit trips flag", discarding, 1);
    chk("R5", "frameCnt unchanged", frameCnt, 5);
  endtask

  task automatic tSaturate();
    wrLimit(8'h00, 8'h00);
    frameStart();
    @(negedge clk); byteValid = 1'b1;
    for (int i = 0; i < 8200; i++) begin
      byteData = 8'(i);
      @(negedge clk);
    end
    #1;
    chk("R8", "fifoWrEn past 8191", fifoWrEn, 1);
    byteValid = 1'b0;
    @(negedge clk);
    chk("R8", "frameCnt saturates", frameCnt, 13'h1FFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tLimitRegs();
    tOverflow();
    tClear();
    tLowerMidFrame();
    tSaturate();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vecs++;
    errs++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule